// File: doc/BRIEF.md
# Three-Leg Gate Interlock with Deadtime

This block sits between a PWM generator and the gate drivers of a three-phase bridge. For each of the three legs it takes one active-high request for the upper switch and one for the lower switch. It produces the two gate enables for that leg. The two enables of a leg are never on together, and a switch may only turn on once the leg has been fully off for a fixed deadtime. All six requests pass through a synchroniser before any decision is made on them.

When both requests of a leg are active at once, the request that was granted first keeps the leg. The other request waits until the first is released, then takes over after the deadtime. If both requests arrive in the same synchronised cycle, neither one wins, and the leg stays off until one of them drops. A fault manager on the same clock can assert a shutdown input that turns every gate off. The deadtime is set in nanoseconds and converted to clock cycles from the clock frequency parameter.

Top module: `leg_gate_guard`

## Requirements
- R1: While reset is low all six outputs are 0. After reset is released, no output goes high before the DEAD_CYC-th rising clock edge after release. A request held through reset turns on at exactly that edge.
- R2: In every cycle, no leg has its upper and lower gate outputs high together.
- R3: While one side of a leg holds the grant and its output is on, asserting the other side's request has no effect: the granted output stays on and the other output stays off.
- R4: When the granted request drops while the other request of the same leg is still held, the held side takes the grant. Its output goes high exactly DEAD_CYC cycles after the first output went low.
- R5: If both requests of a leg become active in the same synchronised cycle, both outputs of that leg stay low until one request drops. The remaining request is then granted.
- R6: The deadtime is DEAD_CYC = ceil(DEAD_NS * CLK_MHZ / 1000) cycles, with a minimum of 1 (19 at the defaults of 380 ns and 50 MHz). After any output of a leg goes low, neither output of that leg goes high for at least DEAD_CYC cycles, even when requests pulse for only a few cycles.
- R7: With the deadtime expired, a request that changes before a rising edge changes its output at the SYNC_STAGES+1-th rising edge (the third edge at the defaults). This holds for both turn-on and turn-off.
- R8: When killAll is high at a rising edge, all six outputs are low after that edge and stay low while it is held. Each output that is switched off this way restarts its leg's deadtime. Once killAll is low again, granted requests turn on as soon as the deadtime has run out.
- R9: The three legs are independent: the requests of one leg never change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmHiReq | input | NUM_LEGS | Upper-switch requests, bit i is leg i |
| pwmLoReq | input | NUM_LEGS | Lower-switch requests, bit i is leg i |
| killAll | input | 1 | Synchronous shutdown from the fault manager, active high |
| gateHi | output | NUM_LEGS | Upper-switch gate enables |
| gateLo | output | NUM_LEGS | Lower-switch gate enables |

## Verification
Two things can land on the same edge and must be judged together. The first is a leg's handover, when one side's turn-off and the opposite side's grant happen in one cycle. The second is the shutdown input, which turns a gate off at the same moment the deadtime counter is reloaded or the grant moves. Directed steps line up a request release and a killAll pulse against a leg that is already on. Random phases pulse killAll during request churn that includes pulses shorter than the deadtime. A cycle-level reference model computed from the requirements judges every output, and independent gap and overlap monitors confirm that the deadtime and the interlock hold no matter how the two coincide.

// File: rtl/gate_pkg.sv
package gate_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HI   = 2'd1,
    OWN_LO   = 2'd2,
    OWN_TIE  = 2'd3
  } own_e;

  // per-leg strobes from control to datapath
  typedef struct packed {
    logic grantHi;
    logic grantLo;
  } legStrobe_t;

  // cycles of deadtime, rounded up, never below one
  function automatic int deadCycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/leg_arbiter.sv
module leg_arbiter
  import gate_pkg::*;
#(
  parameter int NUM_LEGS = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_LEGS-1:0]       reqHiSync,
  input  logic [NUM_LEGS-1:0]       reqLoSync,
  output legStrobe_t [NUM_LEGS-1:0] strobes
);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    own_e ownQ, ownNext;
    logic h, l;

    assign h = reqHiSync[g];
    assign l = reqLoSync[g];

    // first-come ownership; a same-cycle arrival parks in OWN_TIE
    always_comb begin
      ownNext = ownQ;
      unique case (ownQ)
        OWN_HI: begin
          if (!h) ownNext = l ? OWN_LO : OWN_NONE;
        end
        OWN_LO: begin
          if (!l) ownNext = h ? OWN_HI : OWN_NONE;
        end
        default: begin
          if (h && l)  ownNext = OWN_TIE;
          else if (h)  ownNext = OWN_HI;
          else if (l)  ownNext = OWN_LO;
          else         ownNext = OWN_NONE;
        end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ownQ <= OWN_NONE;
      else       ownQ <= ownNext;
    end

    assign strobes[g].grantHi = (ownNext == OWN_HI);
    assign strobes[g].grantLo = (ownNext == OWN_LO);
  end

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int NUM_LEGS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYC    = 19
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_LEGS-1:0]       pwmHiReq,
  input  logic [NUM_LEGS-1:0]       pwmLoReq,
  input  logic                      killAll,
  input  legStrobe_t [NUM_LEGS-1:0] strobes,
  output logic [NUM_LEGS-1:0]       reqHiSync,
  output logic [NUM_LEGS-1:0]       reqLoSync,
  output logic [NUM_LEGS-1:0]       gateHi,
  output logic [NUM_LEGS-1:0]       gateLo
);

  localparam int CNT_W = $clog2(DEAD_CYC + 1);
  // reload one short so the off gap is exactly DEAD_CYC cycles
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DEAD_CYC - 1);

  gate_sync #(.WIDTH(NUM_LEGS), .STAGES(SYNC_STAGES)) uSyncHi (
    .clk(clk), .rstN(rstN), .din(pwmHiReq), .dout(reqHiSync)
  );

  gate_sync #(.WIDTH(NUM_LEGS), .STAGES(SYNC_STAGES)) uSyncLo (
    .clk(clk), .rstN(rstN), .din(pwmLoReq), .dout(reqLoSync)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    logic [CNT_W-1:0] deadCnt;
    logic hiQ, loQ;
    logic wantHi, wantLo, hiDrop, loDrop, legFree;

    assign wantHi  = strobes[g].grantHi & ~killAll;
    assign wantLo  = strobes[g].grantLo & ~killAll;
    assign hiDrop  = hiQ & ~wantHi;
    assign loDrop  = loQ & ~wantLo;
    assign legFree = ~hiQ & ~loQ & (deadCnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiQ     <= 1'b0;
        loQ     <= 1'b0;
        deadCnt <= RELOAD;
      end else begin
        if (hiDrop || loDrop)     deadCnt <= RELOAD;
        else if (deadCnt != '0)   deadCnt <= deadCnt - CNT_W'(1);

        if (hiDrop)                         hiQ <= 1'b0;
        else if (legFree && wantHi && !wantLo) hiQ <= 1'b1;

        if (loDrop)                         loQ <= 1'b0;
        else if (legFree && wantLo && !wantHi) loQ <= 1'b1;
      end
    end

    assign gateHi[g] = hiQ;
    assign gateLo[g] = loQ;
  end

endmodule

// File: rtl/leg_gate_guard.sv
module leg_gate_guard
  import gate_pkg::*;
#(
  parameter int NUM_LEGS    = 3,
  parameter int CLK_MHZ     = 50,
  parameter int DEAD_NS     = 380,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LEGS-1:0] pwmHiReq,
  input  logic [NUM_LEGS-1:0] pwmLoReq,
  input  logic                killAll,
  output logic [NUM_LEGS-1:0] gateHi,
  output logic [NUM_LEGS-1:0] gateLo
);

  localparam int DEAD_CYC = deadCycles(DEAD_NS, CLK_MHZ);

  logic [NUM_LEGS-1:0]       reqHiSync, reqLoSync;
  legStrobe_t [NUM_LEGS-1:0] strobes;

  leg_arbiter #(.NUM_LEGS(NUM_LEGS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqHiSync(reqHiSync), .reqLoSync(reqLoSync),
    .strobes(strobes)
  );

  gate_datapath #(
    .NUM_LEGS(NUM_LEGS), .SYNC_STAGES(SYNC_STAGES), .DEAD_CYC(DEAD_CYC)
  ) uData (
    .clk(clk), .rstN(rstN),
    .pwmHiReq(pwmHiReq), .pwmLoReq(pwmLoReq), .killAll(killAll),
    .strobes(strobes),
    .reqHiSync(reqHiSync), .reqLoSync(reqLoSync),
    .gateHi(gateHi), .gateLo(gateLo)
  );

endmodule

// File: rtl/gate_guard_checker.sv
module gate_guard_checker #(
  parameter int NUM_LEGS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYC    = 19
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_LEGS-1:0] pwmHiReq,
  input logic [NUM_LEGS-1:0] pwmLoReq,
  input logic                killAll,
  input logic [NUM_LEGS-1:0] gateHi,
  input logic [NUM_LEGS-1:0] gateLo
);

  localparam int GW  = $clog2(DEAD_CYC + 1);
  localparam int LAT = SYNC_STAGES + 1;

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi & gateLo) == '0);  // R2

  AST_KILL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    killAll |=> (gateHi == '0 && gateLo == '0));  // R8

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    logic [GW-1:0] offGap;

    // consecutive sampled cycles with the whole leg off, saturating
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        offGap <= '0;
      else if (gateHi[g] || gateLo[g])  offGap <= '0;
      else if (offGap != GW'(DEAD_CYC)) offGap <= offGap + GW'(1);
    end

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateHi[g]) || $rose(gateLo[g])) |-> (offGap >= GW'(DEAD_CYC)));  // R6

    AST_HI_BACKED: assert property (@(posedge clk) disable iff (!rstN)
      gateHi[g] |-> $past(pwmHiReq[g], LAT));  // R7

    AST_LO_BACKED: assert property (@(posedge clk) disable iff (!rstN)
      gateLo[g] |-> $past(pwmLoReq[g], LAT));  // R7
  end

endmodule

bind leg_gate_guard gate_guard_checker #(
  .NUM_LEGS(NUM_LEGS), .SYNC_STAGES(SYNC_STAGES), .DEAD_CYC(DEAD_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .pwmHiReq(pwmHiReq), .pwmLoReq(pwmLoReq),
  .killAll(killAll), .gateHi(gateHi), .gateLo(gateLo)
);

// File: tb/leg_gate_guard_test.sv
module leg_gate_guard_test;

  localparam int LEGS = 3;
  localparam int MHZ  = 50;
  localparam int DNS  = 380;
  localparam int STG  = 2;
  localparam int DEAD = ((DNS * MHZ + 999) / 1000 < 1) ? 1 : (DNS * MHZ + 999) / 1000;
  localparam int LAT  = STG + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LEGS-1:0] hiReq = '0, loReq = '0;
  logic kill = 1'b0;
  logic [LEGS-1:0] gHi, gLo;

  always #10 clk = ~clk;  // 50 MHz

  leg_gate_guard #(.NUM_LEGS(LEGS), .CLK_MHZ(MHZ), .DEAD_NS(DNS), .SYNC_STAGES(STG)) uut (
    .clk(clk), .rstN(rstN), .pwmHiReq(hiReq), .pwmLoReq(loReq),
    .killAll(kill), .gateHi(gHi), .gateLo(gLo)
  );

  int nChecks = 0, nFails = 0;
  string phase = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  // reference model built from the requirements
  logic [LEGS-1:0] s1h, s2h, s1l, s2l, mHi, mLo;
  int mOwn [LEGS];
  int mCnt [LEGS];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1h <= '0; s2h <= '0; s1l <= '0; s2l <= '0; mHi <= '0; mLo <= '0;
      for (int i = 0; i < LEGS; i++) begin mOwn[i] <= 0; mCnt[i] <= DEAD - 1; end
    end else begin
      s1h <= hiReq; s2h <= s1h; s1l <= loReq; s2l <= s1l;
      for (int i = 0; i < LEGS; i++) begin
        int no;
        bit h, l, wh, wl, dh, dl, fr;
        h = s2h[i]; l = s2l[i];
        case (mOwn[i])
          1:       no = h ? 1 : (l ? 2 : 0);
          2:       no = l ? 2 : (h ? 1 : 0);
          default: no = (h && l) ? 3 : (h ? 1 : (l ? 2 : 0));
        endcase
        wh = (no == 1) && !kill;
        wl = (no == 2) && !kill;
        dh = mHi[i] && !wh;
        dl = mLo[i] && !wl;
        fr = !mHi[i] && !mLo[i] && (mCnt[i] == 0);
        mOwn[i] <= no;
        if (dh || dl) mCnt[i] <= DEAD - 1;
        else if (mCnt[i] > 0) mCnt[i] <= mCnt[i] - 1;
        if (dh) mHi[i] <= 1'b0; else if (fr && wh) mHi[i] <= 1'b1;
        if (dl) mLo[i] <= 1'b0; else if (fr && wl) mLo[i] <= 1'b1;
      end
    end
  end

  // independent gap and overlap monitors, run on each falling edge
  int gap [LEGS];
  logic [LEGS-1:0] pHi = '0, pLo = '0;

  task automatic step();
    @(negedge clk);
    check({gHi, gLo} == {mHi, mLo}, phase, {gHi, gLo}, {mHi, mLo});
    check((gHi & gLo) == '0, "R2", gHi & gLo, 0);
    for (int i = 0; i < LEGS; i++) begin
      if (!rstN) gap[i] = 1;  // release cycle counts as off
      else begin
        if ((gHi[i] && !pHi[i]) || (gLo[i] && !pLo[i]))
          check(gap[i] >= DEAD, "R6", gap[i], DEAD);
        if (gHi[i] || gLo[i]) gap[i] = 0; else gap[i] = gap[i] + 1;
      end
    end
    pHi = gHi; pLo = gLo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state with a request held through reset
    hiReq[0] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check(gHi == '0 && gLo == '0, "R1", {gHi, gLo}, 0);
    end
    rstN = 1'b1;
    for (int k = 1; k <= DEAD + 6; k++) begin
      step();
      check(gHi[0] == (k >= DEAD), "R1", gHi[0], k >= DEAD);
    end

    // R3: the later request is ignored while the first holds
    phase = "R3";
    loReq[0] = 1'b1;
    for (int k = 0; k < 30; k++) begin
      step();
      check(gHi[0] && !gLo[0], "R3", {gHi[0], gLo[0]}, 2);
    end

    // R4: handover after release, exact deadtime
    phase = "R4";
    hiReq[0] = 1'b0;
    for (int k = 1; k <= DEAD + 10; k++) begin
      step();
      check(gHi[0] == (k < LAT), "R4", gHi[0], k < LAT);
      check(gLo[0] == (k >= LAT + DEAD), "R4", gLo[0], k >= LAT + DEAD);
    end
    loReq[0] = 1'b0;
    repeat (DEAD + 5) step();

    // R5: simultaneous arrival on leg 1
    phase = "R5";
    hiReq[1] = 1'b1; loReq[1] = 1'b1;
    for (int k = 0; k < 40; k++) begin
      step();
      check(!gHi[1] && !gLo[1], "R5", {gHi[1], gLo[1]}, 0);
    end
    loReq[1] = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      step();
      check(gHi[1] == (k >= LAT) && !gLo[1], "R5", {gHi[1], gLo[1]}, (k >= LAT) ? 2 : 0);
    end
    hiReq[1] = 1'b0;
    repeat (DEAD + 5) step();

    // R7: latency of rise and fall
    phase = "R7";
    loReq[2] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      step();
      check(gLo[2] == (k >= LAT), "R7", gLo[2], k >= LAT);
    end
    loReq[2] = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      step();
      check(gLo[2] == (k < LAT), "R7", gLo[2], k < LAT);
    end
    repeat (DEAD + 5) step();

    // R8: shutdown while two legs are on
    phase = "R8";
    hiReq[0] = 1'b1; loReq[2] = 1'b1;
    repeat (LAT + 4) step();
    kill = 1'b1;
    for (int k = 0; k < DEAD + 10; k++) begin
      step();
      check(gHi == '0 && gLo == '0, "R8", {gHi, gLo}, 0);
    end
    kill = 1'b0;
    step();
    check(gHi[0] && gLo[2], "R8", {gHi, gLo}, {3'b001, 3'b100});
    kill = 1'b1;
    step();
    check(gHi == '0 && gLo == '0, "R8", {gHi, gLo}, 0);
    kill = 1'b0;
    repeat (DEAD + 5) step();
    hiReq = '0; loReq = '0;
    repeat (DEAD + 5) step();

    // R9: random churn per leg, short pulses and shutdown pulses included
    phase = "R9";
    begin
      int hold [LEGS];
      int killLeft;
      killLeft = 0;
      for (int i = 0; i < LEGS; i++) hold[i] = 0;
      for (int c = 0; c < 6000; c++) begin
        step();
        for (int i = 0; i < LEGS; i++) begin
          if (hold[i] == 0) begin
            int pat;
            pat = $urandom % 4;
            hiReq[i] = pat[0];
            loReq[i] = pat[1];
            hold[i] = ($urandom % 4 == 0) ? 1 + $urandom % 5 : 1 + $urandom % 60;
          end else hold[i]--;
        end
        if (killLeft > 0) killLeft--;
        else if ($urandom % 300 == 0) killLeft = 1 + $urandom % 8;
        kill = (killLeft > 0);
      end
    end
    hiReq = '0; loReq = '0; kill = 1'b0;
    repeat (DEAD + 5) step();

    summary();
    $finish;
  end

endmodule